// File: doc/BRIEF.md
# Muxed Burst NOR Read Sequencer

This block is the read front end of a synchronous NOR memory whose address and data travel on one shared 16-bit bus. When the host pulses address-valid, the low half of the word address is taken from the shared bus and the high part from dedicated address pins. The sequencer then holds off for a programmable number of wait clocks, and after that it issues one 16-bit word per clock. Each word comes with a data-valid strobe and the word address it belongs to.

A small configuration register selects the burst type, the wrap behaviour, the first-data latency and the ready timing. The burst can be an endless linear stream, or an 8- or 16-word burst that either wraps inside its aligned group or keeps counting straight through it. A ready handshake tells the host when words are valid, and it can be set to lead the data by one clock. The storage array is stood in for by a fixed lookup that computes each word from its address. The pad logic uses the separate bus driver enable to tri-state the shared bus.

Top module: `nbr_burst_read`

## Requirements
- R1: On a clock edge where `addr_valid` and `chip_en` are both high, the start word address {`addr_hi`, `bus_in`} is latched. A burst already in progress is abandoned and the sequence restarts from the new address.
- R2: With wait code W in `cfg_wdata[3:0]`, `data_valid` first goes high after the (W+3)th rising edge that follows the capture edge. The first word is therefore sampled on the (W+4)th edge, counting the capture edge as the first.
- R3: With config bit 7 set, `ready` rises one cycle before each run of valid words and falls one cycle before that run ends. With bit 7 clear, `ready` equals `data_valid` in every cycle.
- R4: Continuous mode (`cfg[5:4]` = 00, and the unused code 11 behaves the same) adds one to the word address on every beat. The burst has no end while `chip_en` stays high.
- R5: In continuous mode, a beat whose address is a nonzero-distance step onto a multiple of 2^21 enters a new bank (the bank is the top 4 address bits). Exactly GAP_CYC cycles (default 2) with `data_valid` and `ready` low come before that beat.
- R6: With `cfg[5:4]` = 01 (8 words) or 10 (16 words) and `cfg[6]` = 1, exactly N beats are delivered. Every address stays inside the aligned N-word group, and the address returns to the group's first word after its last word.
- R7: With a fixed length and `cfg[6]` = 0, exactly N beats are delivered, each address one above the previous, crossing the group boundary without a stall.
- R8: When `chip_en` is low at an edge, the burst aborts. From that edge on, `data_valid` and `ready` are low.
- R9: `bus_drv_en` is high exactly when `out_en`, `chip_en` and `data_valid` are all high. `out_en` has no effect on the word sequence or its timing.
- R10: The configuration register resets to 8'h8B (ready leads data, continuous, no wrap, wait code 1011). It is written through `cfg_we`/`cfg_wdata`. A write during a burst leaves that burst unchanged and applies from the next capture.
- R11: During a valid beat, `word_addr` is that beat's address and `bus_out` equals `word_addr[15:0] ^ {7'b0, word_addr[24:16]} ^ 16'hA5C3`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip enable, active high; low aborts a burst |
| out_en | input | 1 | Output enable, gates only the bus driver |
| addr_valid | input | 1 | Address-valid strobe for the shared bus |
| addr_hi | input | 9 | Upper word address bits |
| bus_in | input | 16 | Shared bus as seen at the input pads |
| bus_out | output | 16 | Word driven toward the shared bus |
| bus_drv_en | output | 1 | Pad driver enable for the shared bus |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration value: [7] ready leads, [6] wrap, [5:4] mode, [3:0] wait code |
| data_valid | output | 1 | Word on `bus_out` is valid this cycle |
| ready | output | 1 | Ready handshake to the host |
| word_addr | output | 25 | Word address of the current beat |

## Verification
Some properties are checked by assertions on every cycle. A low `chip_en` clears `data_valid` at the next edge. A wrapping fixed burst never leaves its aligned group. A fixed burst never counts past its length. Two back-to-back continuous beats always share a bank. A rising `data_valid` in lead mode was always announced by `ready` one cycle earlier. Other behaviour can only be shown by the bench scenarios, which compare cycle by cycle against an independent model for every mode, wrap, wait code and ready setting. These cover the exact first-data latency, the count of bank-crossing gap cycles, restart on a new address, the reset default configuration, and a configuration write that must not touch the burst in flight.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

  typedef enum logic [1:0] {
    BM_CONT  = 2'b00,
    BM_LEN8  = 2'b01,
    BM_LEN16 = 2'b10,
    BM_RSVD  = 2'b11
  } burst_mode_e;

  // Field order equals the bit order of the write port.
  typedef struct packed {
    logic        rdy_early;
    logic        wrap;
    burst_mode_e mode;
    logic [3:0]  wait_code;
  } rd_cfg_t;

  localparam rd_cfg_t CFG_RESET = '{rdy_early: 1'b1, wrap: 1'b0,
                                    mode: BM_CONT, wait_code: 4'b1011};

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_WAIT,
    SQ_BEAT,
    SQ_GAP
  } seq_state_e;

  localparam int MAX_LEN = 16;

endpackage

// File: rtl/nbr_cfg_reg.sv
module nbr_cfg_reg
  import nbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output rd_cfg_t    cfg
);

  rd_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = rd_cfg_t'(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else if (wr_en) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/nbr_addr_step.sv
module nbr_addr_step
  import nbr_pkg::*;
#(
  parameter int ADDR_W   = 25,
  parameter int BANK_LSB = 21
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  burst_mode_e       mode,
  input  logic              wrap,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic              bank_cross
);

  logic [ADDR_W-1:0] inc;
  logic [ADDR_W-1:0] grp_mask;
  logic              fixed_len;

  assign fixed_len = (mode == BM_LEN8) || (mode == BM_LEN16);
  assign grp_mask  = (mode == BM_LEN16) ? ADDR_W'(MAX_LEN - 1) : ADDR_W'(7);
  assign inc       = cur_addr + ADDR_W'(1);

  always_comb begin
    if (fixed_len && wrap) nxt_addr = (cur_addr & ~grp_mask) | (inc & grp_mask);
    else                   nxt_addr = inc;
  end

  assign bank_cross = !fixed_len && (nxt_addr[BANK_LSB-1:0] == '0);

endmodule

// File: rtl/nbr_word_rom.sv
module nbr_word_rom #(
  parameter int ADDR_W = 25,
  parameter int BUS_W  = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BUS_W-1:0]  word
);

  localparam logic [BUS_W-1:0] SALT = BUS_W'(16'hA5C3);

  assign word = addr[BUS_W-1:0] ^ BUS_W'(addr >> BUS_W) ^ SALT;

endmodule

// File: rtl/nbr_rd_fsm.sv
module nbr_rd_fsm
  import nbr_pkg::*;
#(
  parameter int ADDR_W   = 25,
  parameter int BANK_LSB = 21,
  parameter int GAP_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] cap_addr,
  input  rd_cfg_t           cfg_live,
  input  logic [ADDR_W-1:0] nxt_addr,
  input  logic              bank_cross,
  output logic [ADDR_W-1:0] cur_addr,
  output rd_cfg_t           act_cfg,
  output logic              data_valid,
  output logic              ready
);

  localparam int WAIT_TOP = (1 << $bits(cfg_live.wait_code)) + 1;
  localparam int CNT_MAX  = (WAIT_TOP > GAP_CYC) ? WAIT_TOP : GAP_CYC;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam int BEAT_W   = $clog2(MAX_LEN);

  seq_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  rd_cfg_t           cfg_q;
  logic              cap_en;
  logic              is_fixed;
  logic [BEAT_W-1:0] last_beat;
  logic              rdy_next;
  logic [ADDR_W-1:0] grp_mask;

  assign cap_en    = chip_en && addr_valid;
  assign is_fixed  = (cfg_q.mode == BM_LEN8) || (cfg_q.mode == BM_LEN16);
  assign last_beat = (cfg_q.mode == BM_LEN16) ? BEAT_W'(MAX_LEN - 1) : BEAT_W'(7);
  assign grp_mask  = (cfg_q.mode == BM_LEN16) ? ADDR_W'(MAX_LEN - 1) : ADDR_W'(7);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    addr_d = addr_q;
    beat_d = beat_q;
    if (!chip_en) begin
      st_d = SQ_IDLE;
    end else if (addr_valid) begin
      st_d   = SQ_WAIT;
      cnt_d  = CNT_W'(cfg_live.wait_code) + CNT_W'(2);
      addr_d = cap_addr;
      beat_d = '0;
    end else begin
      unique case (st_q)
        SQ_WAIT: begin
          if (cnt_q == '0) st_d = SQ_BEAT;
          else             cnt_d = cnt_q - CNT_W'(1);
        end
        SQ_BEAT: begin
          if (is_fixed && (beat_q == last_beat)) begin
            st_d = SQ_IDLE;
          end else begin
            addr_d = nxt_addr;
            beat_d = beat_q + BEAT_W'(1);
            if (bank_cross) begin
              st_d  = SQ_GAP;
              cnt_d = CNT_W'(GAP_CYC - 1);
            end
          end
        end
        SQ_GAP: begin
          if (cnt_q == '0) st_d = SQ_BEAT;
          else             cnt_d = cnt_q - CNT_W'(1);
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      beat_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      beat_q <= beat_d;
    end
  end

  // Settings are frozen at capture; writes in mid-burst wait for the next one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_RESET;
    else if (cap_en) cfg_q <= cfg_live;
  end

  assign rdy_next = ((st_q == SQ_WAIT) && (cnt_q == '0)) ||
                    ((st_q == SQ_GAP)  && (cnt_q == '0)) ||
                    ((st_q == SQ_BEAT) && !(is_fixed && (beat_q == last_beat)) && !bank_cross);

  assign data_valid = (st_q == SQ_BEAT);
  assign ready      = cfg_q.rdy_early ? rdy_next : data_valid;
  assign cur_addr   = addr_q;
  assign act_cfg    = cfg_q;

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) !chip_en |=> !data_valid); // R8
  AST_WRAP_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n) (st_q == SQ_BEAT && st_d == SQ_BEAT && is_fixed && cfg_q.wrap) |=> ((addr_q & ~grp_mask) == $past(addr_q & ~grp_mask))); // R6
  AST_FIXED_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (data_valid && is_fixed) |-> (beat_q <= last_beat)); // R7
  AST_NO_BANK_SKIP: assert property (@(posedge clk) disable iff (!rst_n) (data_valid && $past(data_valid) && !is_fixed) |-> (addr_q[ADDR_W-1:BANK_LSB] == $past(addr_q[ADDR_W-1:BANK_LSB]))); // R5
  AST_READY_LEADS: assert property (@(posedge clk) disable iff (!rst_n) ($rose(data_valid) && cfg_q.rdy_early) |-> $past(ready)); // R3

endmodule

// File: rtl/nbr_burst_read.sv
module nbr_burst_read
  import nbr_pkg::*;
#(
  parameter int ADDR_W  = 25,
  parameter int BUS_W   = 16,
  parameter int BANK_W  = 4,
  parameter int GAP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              out_en,
  input  logic              addr_valid,
  input  logic [ADDR_W-BUS_W-1:0] addr_hi,
  input  logic [BUS_W-1:0]  bus_in,
  output logic [BUS_W-1:0]  bus_out,
  output logic              bus_drv_en,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic              data_valid,
  output logic              ready,
  output logic [ADDR_W-1:0] word_addr
);

  localparam int BANK_LSB = ADDR_W - BANK_W;

  logic [1:0]        rs_q;
  logic              rst_core_n;
  rd_cfg_t           cfg_live;
  rd_cfg_t           act_cfg;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] nxt_addr;
  logic              bank_cross;
  logic [BUS_W-1:0]  rom_word;

  // Reset asserts at once and is released two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  nbr_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .cfg     (cfg_live)
  );

  nbr_addr_step #(.ADDR_W(ADDR_W), .BANK_LSB(BANK_LSB)) u_step (
    .cur_addr   (cur_addr),
    .mode       (act_cfg.mode),
    .wrap       (act_cfg.wrap),
    .nxt_addr   (nxt_addr),
    .bank_cross (bank_cross)
  );

  nbr_rd_fsm #(.ADDR_W(ADDR_W), .BANK_LSB(BANK_LSB), .GAP_CYC(GAP_CYC)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .chip_en    (chip_en),
    .addr_valid (addr_valid),
    .cap_addr   ({addr_hi, bus_in}),
    .cfg_live   (cfg_live),
    .nxt_addr   (nxt_addr),
    .bank_cross (bank_cross),
    .cur_addr   (cur_addr),
    .act_cfg    (act_cfg),
    .data_valid (data_valid),
    .ready      (ready)
  );

  nbr_word_rom #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_rom (
    .addr (cur_addr),
    .word (rom_word)
  );

  assign word_addr  = cur_addr;
  assign bus_out    = data_valid ? rom_word : '0;
  assign bus_drv_en = out_en && chip_en && data_valid;

endmodule

// File: tb/nbr_burst_read_tb_top.sv
module nbr_burst_read_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 25;
  localparam int GAP = 2;

  typedef struct packed {
    logic [7:0]    cfg;
    logic [AW-1:0] start;
    logic [4:0]    beat;
    logic [AW-1:0] exp_addr;
  } vec_t;

  // Directed address-sequence vectors: config, start, beat index, expected address.
  localparam vec_t VEC [0:6] = '{
    '{cfg: 8'h50, start: 25'h0000005, beat: 5'd3,  exp_addr: 25'h0000000},
    '{cfg: 8'h60, start: 25'h000001E, beat: 5'd2,  exp_addr: 25'h0000010},
    '{cfg: 8'h10, start: 25'h0000006, beat: 5'd3,  exp_addr: 25'h0000009},
    '{cfg: 8'h00, start: 25'h01FFFFE, beat: 5'd2,  exp_addr: 25'h0200000},
    '{cfg: 8'h20, start: 25'h000000F, beat: 5'd15, exp_addr: 25'h000001E},
    '{cfg: 8'hD0, start: 25'h1FFFFFF, beat: 5'd1,  exp_addr: 25'h1FFFFF8},
    '{cfg: 8'h30, start: 25'h0000007, beat: 5'd9,  exp_addr: 25'h0000010}
  };

  localparam logic [AW-1:0] STARTS [0:3] = '{25'h0000005, 25'h01FFFF6, 25'h1FFFFFA, 25'h0ABCDE9};

  logic          clk;
  logic          rst_n;
  logic          chip_en;
  logic          out_en;
  logic          addr_valid;
  logic [8:0]    addr_hi;
  logic [15:0]   bus_in;
  logic [15:0]   bus_out;
  logic          bus_drv_en;
  logic          cfg_we;
  logic [7:0]    cfg_wdata;
  logic          data_valid;
  logic          ready;
  logic [AW-1:0] word_addr;

  nbr_burst_read dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_en    (chip_en),
    .out_en     (out_en),
    .addr_valid (addr_valid),
    .addr_hi    (addr_hi),
    .bus_in     (bus_in),
    .bus_out    (bus_out),
    .bus_drv_en (bus_drv_en),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .data_valid (data_valid),
    .ready      (ready),
    .word_addr  (word_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk;
  int n_fail;
  bit done;

  logic          dv_e [0:63];
  logic [AW-1:0] ad_e [0:63];
  logic [AW-1:0] obs_addr [0:63];
  int            n_obs;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] model_word(input logic [AW-1:0] a);
    return a[15:0] ^ {7'b0, a[24:16]} ^ 16'hA5C3;
  endfunction

  function automatic bit mode_fixed(input logic [7:0] cfg);
    return (cfg[5:4] == 2'b01) || (cfg[5:4] == 2'b10);
  endfunction

  // Reference schedule from the requirements: index k = edges after capture.
  task automatic build_model(input logic [7:0] cfg, input logic [AW-1:0] start);
    int n;
    int k;
    logic [AW-1:0] a;
    logic [AW-1:0] msk;
    for (int i = 0; i < 64; i++) begin
      dv_e[i] = 1'b0;
      ad_e[i] = '0;
    end
    n   = (cfg[5:4] == 2'b01) ? 8 : (cfg[5:4] == 2'b10) ? 16 : 60;
    msk = AW'(n - 1);
    k   = int'(cfg[3:0]) + 3;
    for (int j = 0; j < n; j++) begin
      if (mode_fixed(cfg) && cfg[6]) a = (start & ~msk) | ((start + AW'(j)) & msk);
      else                           a = start + AW'(j);
      if (!mode_fixed(cfg) && j > 0 && a[20:0] == 21'd0) k = k + GAP;
      if (k >= 64) break;
      dv_e[k] = 1'b1;
      ad_e[k] = a;
      k++;
    end
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // Called at a falling edge; returns at the falling edge after the capture edge.
  task automatic start_cap(input logic [AW-1:0] a);
    chip_en    = 1'b1;
    addr_valid = 1'b1;
    addr_hi    = a[24:16];
    bus_in     = a[15:0];
    @(negedge clk);
    addr_valid = 1'b0;
    bus_in     = 16'hDEAD;
  endtask

  task automatic observe(input logic [7:0] cfg, input logic [AW-1:0] start, input int kmax,
                         input bit oe, input bit mid_wr, input logic [7:0] mid_val);
    string mt;
    string at;
    bit    exp_rdy;
    build_model(cfg, start);
    n_obs  = 0;
    out_en = oe;
    if (mode_fixed(cfg)) begin
      mt = cfg[6] ? "R6" : "R7";
      at = mt;
    end else begin
      mt = "R5";
      at = "R4";
    end
    for (int k = 1; k <= kmax; k++) begin
      if (mid_wr && k == 1) begin
        cfg_we    = 1'b1;
        cfg_wdata = mid_val;
      end
      if (k == 2) cfg_we = 1'b0;
      @(negedge clk);
      exp_rdy = cfg[7] ? dv_e[k + 1] : dv_e[k];
      chk(data_valid == dv_e[k], (k <= int'(cfg[3:0]) + 3) ? "R2" : mt, "data_valid",
          32'(data_valid), 32'(dv_e[k]));
      chk(ready == exp_rdy, "R3", "ready", 32'(ready), 32'(exp_rdy));
      chk(bus_drv_en == (oe && dv_e[k]), "R9", "bus_drv_en", 32'(bus_drv_en), 32'(oe && dv_e[k]));
      if (dv_e[k] && data_valid) begin
        chk(word_addr == ad_e[k], at, "word_addr", 32'(word_addr), 32'(ad_e[k]));
        chk(bus_out == model_word(ad_e[k]), "R11", "bus_out", 32'(bus_out), 32'(model_word(ad_e[k])));
        obs_addr[n_obs] = word_addr;
        n_obs++;
      end
    end
  endtask

  task automatic abort_check();
    chip_en = 1'b0;
    @(negedge clk);
    chk(data_valid == 1'b0, "R8", "data_valid after chip_en low", 32'(data_valid), 32'd0);
    chk(ready == 1'b0, "R8", "ready after chip_en low", 32'(ready), 32'd0);
  endtask

  function automatic int window(input logic [7:0] cfg);
    if (cfg[5:4] == 2'b01) return int'(cfg[3:0]) + 2 + 8 + 2;
    if (cfg[5:4] == 2'b10) return int'(cfg[3:0]) + 2 + 16 + 2;
    return int'(cfg[3:0]) + 3 + 24;
  endfunction

  task automatic run_burst(input logic [7:0] cfg, input logic [AW-1:0] start, input bit oe);
    wr_cfg(cfg);
    start_cap(start);
    observe(cfg, start, window(cfg), oe, 1'b0, 8'h00);
    abort_check();
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      report();
      $finish;
    end
  end

  initial begin
    n_chk      = 0;
    n_fail     = 0;
    done       = 1'b0;
    rst_n      = 1'b0;
    chip_en    = 1'b0;
    out_en     = 1'b0;
    addr_valid = 1'b0;
    addr_hi    = '0;
    bus_in     = '0;
    cfg_we     = 1'b0;
    cfg_wdata  = '0;
    repeat (3) @(negedge clk);
    chk(data_valid == 1'b0, "R10", "data_valid in reset", 32'(data_valid), 32'd0);
    chk(ready == 1'b0, "R10", "ready in reset", 32'(ready), 32'd0);
    chk(bus_drv_en == 1'b0, "R10", "bus_drv_en in reset", 32'(bus_drv_en), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset configuration 8'h8B, first word after 14 edges (R2).
    start_cap(25'h0123450);
    observe(8'h8B, 25'h0123450, window(8'h8B), 1'b1, 1'b0, 8'h00);
    abort_check();

    // Directed vector table (R4, R6, R7, R1).
    foreach (VEC[i]) begin
      run_burst(VEC[i].cfg, VEC[i].start, 1'b1);
      chk(obs_addr[VEC[i].beat] == VEC[i].exp_addr, "R1", "table beat address",
          32'(obs_addr[VEC[i].beat]), 32'(VEC[i].exp_addr));
    end

    // Sweep every mode, wrap, wait code and ready setting.
    for (int m = 0; m < 3; m++)
      for (int wr = 0; wr < 2; wr++)
        for (int w = 0; w < 16; w++)
          for (int e = 0; e < 2; e++)
            run_burst({e[0], wr[0], m[1:0], w[3:0]}, STARTS[(w + e + m) % 4], 1'b1);

    // R8: abort in the middle of a continuous burst.
    wr_cfg(8'h02);
    start_cap(25'h0000100);
    observe(8'h02, 25'h0000100, 8, 1'b1, 1'b0, 8'h00);
    abort_check();

    // R1: a new address pulse mid-burst restarts at the new address.
    wr_cfg(8'h11);
    start_cap(25'h0000200);
    repeat (5) @(negedge clk);
    start_cap(25'h0000345);
    observe(8'h11, 25'h0000345, window(8'h11), 1'b1, 1'b0, 8'h00);
    chk(n_obs == 8, "R1", "beats after restart", 32'(n_obs), 32'd8);
    chk(obs_addr[0] == 25'h0000345, "R1", "first address after restart", 32'(obs_addr[0]), 32'h345);
    abort_check();

    // R9: output enable low leaves the sequence unchanged, driver off.
    run_burst(8'h63, 25'h000004B, 1'b0);
    chk(n_obs == 16, "R9", "beats with out_en low", 32'(n_obs), 32'd16);

    // R10: a config write during a burst only affects the next burst.
    wr_cfg(8'h10);
    start_cap(25'h0000050);
    observe(8'h10, 25'h0000050, window(8'h10), 1'b1, 1'b1, 8'h85);
    chk(n_obs == 8, "R10", "beats of burst during cfg write", 32'(n_obs), 32'd8);
    start_cap(25'h01FFFFC);
    observe(8'h85, 25'h01FFFFC, window(8'h85), 1'b1, 1'b0, 8'h00);
    abort_check();

    done = 1'b1;
    report();
    $finish;
  end

endmodule